// File: doc/BRIEF.md
# Strap-Sampled Configuration Mode Controller

This block fixes a device's configuration mode from a three-level strap and then decides where each configuration setting comes from. The strap reaches the block already resolved into two digital lines: one is asserted when the strap is tied low, and the other when it is tied high. Neither line asserted means the strap is left open. The strap is read only at the moment the internal reset is released. After that the block ignores it until the next reset.

In standalone pin mode, a few shared pads carry the settings directly: output enable, edge rate, divider, output type and input select. In the two host modes (SPI or I2C) those same pads take bus roles instead: clock, select/address, data in and data out. The settings then come from a small register file. The protocol engines are not part of this block; they reach it through a plain register write port. A soft reset bit in register 15 places the block back in reset for a fixed number of cycles. This returns the registers to their defaults and reads the strap again.

Register map: address 0 holds the per-output enables and defaults to all ones. Address 1 is the control register and defaults to zero. In it, bit 0 selects the register-driven input select, bit 1 is that input select value, bits 3:2 are the edge code (00 slow, 01 medium, 10 fast, 11 medium), bit 4 is the divider setting and bit 5 is the output type. Address 15 bit 1 is the soft reset. Writes to any other address are dropped.

Top module: `strap_mode_ctrl`

## Requirements
- R1: The mode is captured only on the clock edge that ends the internal reset. Changes on the strap inputs at any other time leave `mode` unchanged.
- R2: The `mode` encoding follows the strap lines. Only the low line asserted gives 01 (SPI host). Only the high line asserted gives 10 (I2C host). Neither line asserted gives 00 (pin mode). Both lines asserted is illegal and gives 00.
- R3: While `por` is high, `in_reset` is 1 and `mode` is 00. After `por` falls, `in_reset` stays 1 for exactly one more cycle, and the strap is captured on that cycle's closing edge.
- R4: In a host mode, a write to address 15 with bit 1 set makes `in_reset` high for the next SRST_CYCLES cycles (default 4). During that time registers 0 and 1 return to their defaults. The strap is captured again when the reset ends.
- R5: In pin mode every register write has no effect, including the soft reset write.
- R6: In pin mode, every bit of `out_en` equals `pin_oe`.
- R7: In a host mode, `out_en` equals register 0 (default all ones), and `pin_oe` has no effect on it.
- R8: `edge_sel` uses 00 slow, 01 medium and 10 fast. In pin mode it comes from the edge pad: only the low line asserted gives slow, only the high line gives fast, and otherwise it gives medium. In a host mode it comes from register 1 bits 3:2, with code 11 giving medium.
- R9: `in_sel` follows `pin_insel`. The exception is a host mode with register 1 bit 0 set, where `in_sel` takes register 1 bit 1.
- R10: `div_sel` and `out_type` follow `pin_div` and `pin_otype` in pin mode. In a host mode they take register 1 bits 4 and 5.
- R11: In a host mode, `bus_clk` follows `pin_oe`, `bus_sel` follows `pin_erc_hi` and `bus_din` follows `pin_div`, and `bus_dout_en` is 1. In pin mode all four are 0.
- R12: While `in_reset` is 1, `out_en` is all zeros and every register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| strap_lo | input | 1 | Mode strap detected tied low |
| strap_hi | input | 1 | Mode strap detected tied high |
| pin_oe | input | 1 | Output-enable pad / bus clock in host modes |
| pin_erc_lo | input | 1 | Edge-rate pad detected low |
| pin_erc_hi | input | 1 | Edge-rate pad detected high / select or address in host modes |
| pin_div | input | 1 | Divider pad / bus data in for host modes |
| pin_otype | input | 1 | Output-type pad (pin mode only) |
| pin_insel | input | 1 | Input-select pad |
| wr_en | input | 1 | Register write strobe from the bus engine |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| mode | output | 2 | Latched mode: 00 pin, 01 SPI, 10 I2C |
| in_reset | output | 1 | Internal reset active |
| out_en | output | NUM_OUT | Per-output buffer enables |
| edge_sel | output | 2 | Edge rate: 00 slow, 01 medium, 10 fast |
| in_sel | output | 1 | Input multiplexer select |
| div_sel | output | 1 | Input divider setting |
| out_type | output | 1 | Output type setting |
| bus_clk | output | 1 | Bus clock to the host engine |
| bus_sel | output | 1 | Chip select / address line to the host engine |
| bus_din | output | 1 | Serial data in to the host engine |
| bus_dout_en | output | 1 | Output-type pad driven as serial data out |

## Verification
The bench goes after the edge of reset release. A design that captures the strap one cycle early or late, or that keeps following it, would report a mode that tracks later strap changes. It also checks that a soft reset write in pin mode does nothing. A design that fails this would drop into reset and lose its outputs for four cycles. The soft reset window is checked for exact length and for clearing the registers: an off-by-one counter shows up as a wrong `in_reset` cycle. The illegal strap code and the 11 edge code are driven to confirm they fall back to pin mode and medium rather than to a stray encoding.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;

    typedef enum logic [1:0] {
        MODE_PIN = 2'b00,
        MODE_SPI = 2'b01,
        MODE_I2C = 2'b10
    } cfg_mode_t;

    typedef enum logic [1:0] {
        EDGE_SLOW = 2'b00,
        EDGE_MED  = 2'b01,
        EDGE_FAST = 2'b10
    } edge_rate_t;

    localparam int ADDR_W    = 4;
    localparam int REG_W     = 8;
    localparam logic [ADDR_W-1:0] ADDR_OE   = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_SRST = 4'd15;
    localparam int SRST_BIT  = 1;

    // control register fields
    localparam int CTL_INSRC = 0;
    localparam int CTL_INVAL = 1;
    localparam int CTL_EDGE  = 2;
    localparam int CTL_DIV   = 4;
    localparam int CTL_TYPE  = 5;

    localparam logic [REG_W-1:0] OE_DEFAULT   = '1;
    localparam logic [REG_W-1:0] CTRL_DEFAULT = '0;

    function automatic cfg_mode_t decode_strap(input logic lo, input logic hi);
        case ({hi, lo})
            2'b01:   return MODE_SPI;
            2'b10:   return MODE_I2C;
            default: return MODE_PIN;
        endcase
    endfunction

    function automatic edge_rate_t decode_edge_pad(input logic lo, input logic hi);
        case ({hi, lo})
            2'b01:   return EDGE_SLOW;
            2'b10:   return EDGE_FAST;
            default: return EDGE_MED;
        endcase
    endfunction

    function automatic edge_rate_t decode_edge_code(input logic [1:0] code);
        case (code)
            2'b00:   return EDGE_SLOW;
            2'b10:   return EDGE_FAST;
            default: return EDGE_MED;
        endcase
    endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import strap_mode_pkg::*;
#(
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              por,
    input  logic              strap_lo,
    input  logic              strap_hi,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_srst_bit,
    output cfg_mode_t         mode_o,
    output logic              in_reset_o
);

    localparam int CNT_W = $clog2(SRST_CYCLES + 1);

    logic [CNT_W-1:0] rst_cnt;
    cfg_mode_t        mode_q;
    logic             srst_req;

    assign srst_req = wr_en && (mode_q != MODE_PIN) && (wr_addr == ADDR_SRST) && wr_srst_bit;

    always_ff @(posedge clk) begin
        if (por) begin
            rst_cnt <= CNT_W'(1);
            mode_q  <= MODE_PIN;
        end else if (rst_cnt != '0) begin
            rst_cnt <= rst_cnt - CNT_W'(1);
            if (rst_cnt == CNT_W'(1))
                mode_q <= decode_strap(strap_lo, strap_hi);
        end else if (srst_req) begin
            rst_cnt <= CNT_W'(SRST_CYCLES);
        end
    end

    assign mode_o     = mode_q;
    assign in_reset_o = (rst_cnt != '0);

    // window checker for the soft reset length
    logic [CNT_W:0] run_len;
    always_ff @(posedge clk) begin
        if (por || !in_reset_o) run_len <= '0;
        else                    run_len <= run_len + 1'b1;
    end

    // R1
    mode_frozen_chk: assert property (@(posedge clk) disable iff (por)
        (!in_reset_o && !$past(in_reset_o)) |-> $stable(mode_q));

    // R2
    strap_capture_chk: assert property (@(posedge clk) disable iff (por)
        $fell(in_reset_o) |-> (mode_q == decode_strap($past(strap_lo), $past(strap_hi))));

    // R4
    srst_len_chk: assert property (@(posedge clk) disable iff (por)
        run_len <= (CNT_W+1)'(SRST_CYCLES));

    // R5
    pin_no_srst_chk: assert property (@(posedge clk) disable iff (por)
        (mode_q == MODE_PIN && !in_reset_o) |=> !in_reset_o);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import strap_mode_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              in_reset,
    input  cfg_mode_t         mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  oe_reg,
    output logic [REG_W-1:0]  ctrl_reg
);

    logic wr_ok;
    assign wr_ok = wr_en && (mode != MODE_PIN) && !in_reset;

    always_ff @(posedge clk) begin
        if (por || in_reset) begin
            oe_reg   <= OE_DEFAULT;
            ctrl_reg <= CTRL_DEFAULT;
        end else if (wr_ok) begin
            case (wr_addr)
                ADDR_OE:   oe_reg   <= wr_data;
                ADDR_CTRL: ctrl_reg <= wr_data;
                default:   ;
            endcase
        end
    end

    // R5
    pin_regs_hold_chk: assert property (@(posedge clk) disable iff (por)
        (mode == MODE_PIN && !in_reset && !$past(in_reset)) |=> ($stable(oe_reg) && $stable(ctrl_reg)));

endmodule

// File: rtl/pin_router.sv
module pin_router
    import strap_mode_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input  cfg_mode_t          mode,
    input  logic               in_reset,
    input  logic               pin_oe,
    input  logic               pin_erc_lo,
    input  logic               pin_erc_hi,
    input  logic               pin_div,
    input  logic               pin_otype,
    input  logic               pin_insel,
    input  logic [REG_W-1:0]   oe_reg,
    input  logic [REG_W-1:0]   ctrl_reg,
    output logic [NUM_OUT-1:0] out_en,
    output edge_rate_t         edge_sel,
    output logic               in_sel,
    output logic               div_sel,
    output logic               out_type,
    output logic               bus_clk,
    output logic               bus_sel,
    output logic               bus_din,
    output logic               bus_dout_en
);

    logic host;
    assign host = (mode != MODE_PIN);

    always_comb begin
        if (in_reset)  out_en = '0;
        else if (host) out_en = oe_reg[NUM_OUT-1:0];
        else           out_en = {NUM_OUT{pin_oe}};
    end

    always_comb begin
        if (host) begin
            edge_sel = decode_edge_code(ctrl_reg[CTL_EDGE +: 2]);
            in_sel   = ctrl_reg[CTL_INSRC] ? ctrl_reg[CTL_INVAL] : pin_insel;
            div_sel  = ctrl_reg[CTL_DIV];
            out_type = ctrl_reg[CTL_TYPE];
        end else begin
            edge_sel = decode_edge_pad(pin_erc_lo, pin_erc_hi);
            in_sel   = pin_insel;
            div_sel  = pin_div;
            out_type = pin_otype;
        end
    end

    assign bus_clk     = host & pin_oe;
    assign bus_sel     = host & pin_erc_hi;
    assign bus_din     = host & pin_div;
    assign bus_dout_en = host;

endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
    import strap_mode_pkg::*;
#(
    parameter int NUM_OUT     = 8,
    parameter int SRST_CYCLES = 4
) (
    input  logic               clk,
    input  logic               por,
    input  logic               strap_lo,
    input  logic               strap_hi,
    input  logic               pin_oe,
    input  logic               pin_erc_lo,
    input  logic               pin_erc_hi,
    input  logic               pin_div,
    input  logic               pin_otype,
    input  logic               pin_insel,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [7:0]         wr_data,
    output logic [1:0]         mode,
    output logic               in_reset,
    output logic [NUM_OUT-1:0] out_en,
    output logic [1:0]         edge_sel,
    output logic               in_sel,
    output logic               div_sel,
    output logic               out_type,
    output logic               bus_clk,
    output logic               bus_sel,
    output logic               bus_din,
    output logic               bus_dout_en
);

    cfg_mode_t          mode_w;
    edge_rate_t         edge_w;
    logic [REG_W-1:0]   oe_reg;
    logic [REG_W-1:0]   ctrl_reg;

    strap_latch #(.SRST_CYCLES(SRST_CYCLES)) u_latch (
        .clk         (clk),
        .por         (por),
        .strap_lo    (strap_lo),
        .strap_hi    (strap_hi),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_srst_bit (wr_data[SRST_BIT]),
        .mode_o      (mode_w),
        .in_reset_o  (in_reset)
    );

    cfg_regfile u_regs (
        .clk      (clk),
        .por      (por),
        .in_reset (in_reset),
        .mode     (mode_w),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .oe_reg   (oe_reg),
        .ctrl_reg (ctrl_reg)
    );

    pin_router #(.NUM_OUT(NUM_OUT)) u_route (
        .mode        (mode_w),
        .in_reset    (in_reset),
        .pin_oe      (pin_oe),
        .pin_erc_lo  (pin_erc_lo),
        .pin_erc_hi  (pin_erc_hi),
        .pin_div     (pin_div),
        .pin_otype   (pin_otype),
        .pin_insel   (pin_insel),
        .oe_reg      (oe_reg),
        .ctrl_reg    (ctrl_reg),
        .out_en      (out_en),
        .edge_sel    (edge_w),
        .in_sel      (in_sel),
        .div_sel     (div_sel),
        .out_type    (out_type),
        .bus_clk     (bus_clk),
        .bus_sel     (bus_sel),
        .bus_din     (bus_din),
        .bus_dout_en (bus_dout_en)
    );

    assign mode     = mode_w;
    assign edge_sel = edge_w;

    // R12
    rst_outs_off_chk: assert property (@(posedge clk) disable iff (por)
        in_reset |-> (out_en == '0));

    // R11
    bus_idle_chk: assert property (@(posedge clk) disable iff (por)
        (mode == 2'b00) |-> !(bus_clk || bus_sel || bus_din || bus_dout_en));

    // R3
    por_release_chk: assert property (@(posedge clk)
        $fell(por) |-> in_reset);

endmodule

// File: tb/test_strap_mode_ctrl.sv
module test_strap_mode_ctrl;

    localparam int NUM_OUT = 8;
    localparam int SRST    = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic por = 1'b1;
    logic strap_lo = 0, strap_hi = 0;
    logic pin_oe = 0, pin_erc_lo = 0, pin_erc_hi = 0, pin_div = 0, pin_otype = 0, pin_insel = 0;
    logic wr_en = 0;
    logic [3:0] wr_addr = 0;
    logic [7:0] wr_data = 0;

    logic [1:0] mode;
    logic in_reset;
    logic [NUM_OUT-1:0] out_en;
    logic [1:0] edge_sel;
    logic in_sel, div_sel, out_type, bus_clk, bus_sel, bus_din, bus_dout_en;

    strap_mode_ctrl #(.NUM_OUT(NUM_OUT), .SRST_CYCLES(SRST)) i_strap_mode_ctrl (
        .clk(clk), .por(por), .strap_lo(strap_lo), .strap_hi(strap_hi),
        .pin_oe(pin_oe), .pin_erc_lo(pin_erc_lo), .pin_erc_hi(pin_erc_hi),
        .pin_div(pin_div), .pin_otype(pin_otype), .pin_insel(pin_insel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode(mode), .in_reset(in_reset), .out_en(out_en), .edge_sel(edge_sel),
        .in_sel(in_sel), .div_sel(div_sel), .out_type(out_type),
        .bus_clk(bus_clk), .bus_sel(bus_sel), .bus_din(bus_din), .bus_dout_en(bus_dout_en)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // behavioural reference state
    int        m_cnt  = 0;
    int        m_mode = 0;
    bit [7:0]  m_r0   = 8'hFF;
    bit [7:0]  m_r1   = 8'h00;

    function automatic int strap_to_mode(bit lo, bit hi);
        if (lo && !hi) return 1;
        if (hi && !lo) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (por) begin
            m_cnt = 1; m_mode = 0; m_r0 = 8'hFF; m_r1 = 8'h00;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            m_r0 = 8'hFF; m_r1 = 8'h00;
            if (m_cnt == 0) m_mode = strap_to_mode(strap_lo, strap_hi);
        end else if (wr_en && m_mode != 0) begin
            if (wr_addr == 0) m_r0 = wr_data;
            else if (wr_addr == 1) m_r1 = wr_data;
            else if (wr_addr == 15 && wr_data[1]) m_cnt = SRST;
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit host;
        bit [NUM_OUT-1:0] e_oe;
        bit [1:0] e_edge;
        bit e_in, e_div, e_type;
        host = (m_mode != 0);
        if (m_cnt > 0)  e_oe = '0;
        else if (host)  e_oe = m_r0[NUM_OUT-1:0];
        else            e_oe = {NUM_OUT{pin_oe}};
        if (host) begin
            case (m_r1[3:2])
                2'b00: e_edge = 2'b00;
                2'b10: e_edge = 2'b10;
                default: e_edge = 2'b01;
            endcase
            e_in   = m_r1[0] ? m_r1[1] : pin_insel;
            e_div  = m_r1[4];
            e_type = m_r1[5];
        end else begin
            if (pin_erc_lo && !pin_erc_hi)      e_edge = 2'b00;
            else if (pin_erc_hi && !pin_erc_lo) e_edge = 2'b10;
            else                                e_edge = 2'b01;
            e_in   = pin_insel;
            e_div  = pin_div;
            e_type = pin_otype;
        end
        check("R1/R2 mode", 16'(mode), 16'(m_mode));
        check("R3/R4 in_reset", 16'(in_reset), 16'(m_cnt > 0));
        check(host ? "R7/R12 out_en" : "R6/R12 out_en", 16'(out_en), 16'(e_oe));
        check("R8 edge_sel", 16'(edge_sel), 16'(e_edge));
        check("R9 in_sel", 16'(in_sel), 16'(e_in));
        check("R10 div/type", 16'({div_sel, out_type}), 16'({e_div, e_type}));
        check("R11 bus", 16'({bus_clk, bus_sel, bus_din, bus_dout_en}),
              16'({host & pin_oe, host & pin_erc_hi, host & pin_div, host}));
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic wiggle_pins();
        {pin_oe, pin_erc_lo, pin_erc_hi, pin_div, pin_otype, pin_insel} = 6'($urandom);
    endtask

    task automatic do_por(bit lo, bit hi);
        strap_lo = lo; strap_hi = hi; por = 1;
        step(); step();
        por = 0;
        step(); step();
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    initial begin
        step();
        // R3 reset state
        check("R3 mode in por", 16'(mode), 16'd0);
        check("R3 in_reset in por", 16'(in_reset), 16'd1);

        // pin mode: strap open
        do_por(0, 0);
        check("R2 open strap gives pin mode", 16'(mode), 16'd0);
        for (int i = 0; i < 40; i++) begin wiggle_pins(); step(); end
        // R5 writes ignored in pin mode, including soft reset
        wr(4'd0, 8'h00); wr(4'd1, 8'h3F); wr(4'd15, 8'h02);
        step();
        check("R5 soft reset ignored in pin mode", 16'(in_reset), 16'd0);
        // R1 strap change after capture ignored
        strap_lo = 1; step(); step();
        check("R1 strap change ignored", 16'(mode), 16'd0);

        // SPI host
        do_por(1, 0);
        check("R2 low strap gives SPI", 16'(mode), 16'd1);
        pin_oe = 0; step();
        check("R7 default enables, pin_oe ignored", 16'(out_en), 16'hFF);
        strap_lo = 0; strap_hi = 1;
        for (int i = 0; i < 60; i++) begin
            wiggle_pins();
            if (i % 5 == 0) wr(4'(($urandom % 2)), 8'($urandom));
            else step();
        end
        check("R1 SPI held after strap change", 16'(mode), 16'd1);
        // edge code 11 gives medium, register input select
        wr(4'd1, 8'b0000_1111); step();
        check("R8 code 11 medium", 16'(edge_sel), 16'd1);
        check("R9 register input select", 16'(in_sel), 16'd1);
        wr(4'd0, 8'hA5); step();
        // R4 soft reset, strap now high -> I2C
        wr(4'd15, 8'h02);
        check("R4 in reset after write", 16'(in_reset), 16'd1);
        for (int i = 0; i < SRST + 2; i++) begin wiggle_pins(); step(); end
        check("R4 re-sampled I2C", 16'(mode), 16'd2);
        check("R4 enables back to default", 16'(out_en), 16'hFF);

        // I2C host with mixed traffic, including writes during reset (R12)
        for (int i = 0; i < 80; i++) begin
            wiggle_pins();
            if (i % 7 == 0) wr(4'(($urandom % 3 == 0) ? 15 : ($urandom % 2)), 8'($urandom));
            else if (in_reset) wr(4'd0, 8'h00);
            else step();
        end

        // illegal strap: both lines asserted
        do_por(1, 1);
        check("R2 both lines give pin mode", 16'(mode), 16'd0);
        for (int i = 0; i < 30; i++) begin wiggle_pins(); step(); end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule